// File: doc/BRIEF.md
# Block-Match Absolute Difference Accumulator

This engine scores how well a candidate pixel block matches a reference block. It adds up the absolute pixel differences over one 16x16 block. Each operand word carries four unsigned 16-bit pixels side by side. A reference word and a candidate word arrive together on every accepted cycle.

Each lane forms its absolute difference by adding two subtractions that saturate at zero, one in each direction. No magnitude compare or negation is needed. The four lane results of a word are added together in one step. Consecutive words are steered alternately into two 32-bit accumulators, and the result is their sum.

A controller pulses `start`, streams 64 word pairs qualified by `in_valid`, and reads the score once `done` is high. Fetching the blocks and steering a motion search belong to the surrounding logic.

Top module: `sad_engine`

## Requirements
- R1: After reset, `done` is low and `sad_out` is zero. The engine accepts no word until the first `start`.
- R2: Each lane computes |a-b| as satsub(a,b) + satsub(b,a), where satsub returns zero whenever the difference would be negative. Lane i occupies bits 16i+15 down to 16i of both operand words.
- R3: The four lane results of an accepted word are added to the total in one step. `sad_out` shows the updated total in the cycle after the word is accepted.
- R4: Words with an even index inside the block (0, 2, 4, ...) update accumulator A. Words with an odd index update accumulator B. `sad_out` always equals A + B.
- R5: `done` rises in the cycle after the 64th accepted word and stays high until the next `start`.
- R6: While `in_valid` is low, no word is accepted. The word count and `sad_out` keep their values.
- R7: `start` clears both accumulators and the word count and drops `done`. A `start` in the middle of a block abandons that block and begins a new one.
- R8: A word is ignored, with no effect on `sad_out` or on the count, if it is presented before the first `start`, after `done`, or in the same cycle as `start`.
- R9: A full-scale block (every lane 65535 against 0, 64 words) totals 16776960 with no wraparound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new block; clears the total and the count |
| in_valid | input | 1 | Qualifies the operand words in this cycle |
| ref_word | input | 64 | Four reference pixels, lane 0 in the low bits |
| cand_word | input | 64 | Four candidate pixels, lane 0 in the low bits |
| done | output | 1 | High once the block's 64 words have been accepted |
| sad_out | output | 32 | Running total of absolute differences, final when `done` is high |

## Verification
The in-line assertions check, on every cycle:
- at least one of the two saturating terms in each lane is zero;
- a word at an even index leaves accumulator B untouched, and an odd one leaves A untouched;
- the total never decreases within a block;
- the count holds while `in_valid` is low;
- `done` is held and is cleared by `start`.

Only the bench scenarios can show the numbers themselves. These are the lane-by-lane difference values and the lane placement in the word. They also include the exact total after a given word, the cycle in which `done` first rises, and the full-scale total. Likewise, only the bench shows that words arriving while idle, after completion, or together with `start` leave the total unchanged.

// File: rtl/sad_pkg.sv
package sad_pkg;

   // Control phases of one block
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } sad_state_e;

endpackage

// File: rtl/sad_lane_absdiff.sv
module sad_lane_absdiff #(
   parameter int PIX_W = 16
) (
   input  logic [PIX_W-1:0] pix_a,
   input  logic [PIX_W-1:0] pix_b,
   output logic [PIX_W-1:0] abs_diff
);

   logic [PIX_W:0]   d_ab;
   logic [PIX_W:0]   d_ba;
   logic [PIX_W-1:0] up_term;
   logic [PIX_W-1:0] dn_term;

   // The borrow bit selects saturation to zero; no magnitude compare is used
   assign d_ab    = {1'b0, pix_a} - {1'b0, pix_b};
   assign d_ba    = {1'b0, pix_b} - {1'b0, pix_a};
   assign up_term = d_ab[PIX_W] ? '0 : d_ab[PIX_W-1:0];
   assign dn_term = d_ba[PIX_W] ? '0 : d_ba[PIX_W-1:0];
   assign abs_diff = up_term + dn_term;

   always_comb begin
      AST_ONE_TERM_ZERO: assert ((up_term == '0) || (dn_term == '0)); // R2
   end

endmodule

// File: rtl/sad_word_reduce.sv
module sad_word_reduce #(
   parameter int LANES = 4,
   parameter int PIX_W = 16,
   parameter int SUM_W = PIX_W + $clog2(LANES) + 1
) (
   input  logic [LANES*PIX_W-1:0] ref_word,
   input  logic [LANES*PIX_W-1:0] cand_word,
   output logic [SUM_W-1:0]       word_sum
);

   logic [PIX_W-1:0] lane_abs [LANES];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         sad_lane_absdiff #(
            .PIX_W (PIX_W)
         ) u_lane (
            .pix_a    (ref_word [g*PIX_W +: PIX_W]),
            .pix_b    (cand_word[g*PIX_W +: PIX_W]),
            .abs_diff (lane_abs[g])
         );
      end
   endgenerate

   always_comb begin
      word_sum = '0;
      for (int l = 0; l < LANES; l++) begin
         word_sum = word_sum + SUM_W'(lane_abs[l]);
      end
   end

endmodule

// File: rtl/sad_ctrl.sv
module sad_ctrl #(
   parameter int BLOCK_WORDS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic in_valid,
   output logic accept,
   output logic sel_odd,
   output logic done
);

   import sad_pkg::*;

   localparam int CNT_W = $clog2(BLOCK_WORDS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_WORDS - 1);

   sad_state_e       state;
   logic [CNT_W-1:0] cnt;

   assign accept  = (state == ST_RUN) && in_valid && !start;
   assign sel_odd = cnt[0];
   assign done    = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else if (start) begin
         state <= ST_RUN;
         cnt   <= '0;
      end else if (accept) begin
         cnt <= cnt + CNT_W'(1);
         if (cnt == LAST) begin
            state <= ST_DONE;
         end
      end
   end

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done); // R5
   AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(accept)); // R5
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid && !start |=> $stable(cnt)); // R6
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt == '0) && !done); // R7

endmodule

// File: rtl/sad_accum_pair.sv
module sad_accum_pair #(
   parameter int ACC_W = 32,
   parameter int SUM_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             accept,
   input  logic             sel_odd,
   input  logic [SUM_W-1:0] word_sum,
   output logic [ACC_W-1:0] total
);

   logic [ACC_W-1:0] acc_a;
   logic [ACC_W-1:0] acc_b;
   logic [ACC_W-1:0] addend;

   assign addend = ACC_W'(word_sum);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_a <= '0;
         acc_b <= '0;
      end else if (clear) begin
         acc_a <= '0;
         acc_b <= '0;
      end else if (accept) begin
         if (sel_odd) begin
            acc_b <= acc_b + addend;
         end else begin
            acc_a <= acc_a + addend;
         end
      end
   end

   assign total = acc_a + acc_b;

   AST_EVEN_SPARES_B: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !clear && !sel_odd |=> $stable(acc_b)); // R4
   AST_ODD_SPARES_A: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !clear && sel_odd |=> $stable(acc_a)); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !clear |=> total >= $past(total)); // R9

endmodule

// File: rtl/sad_engine.sv
module sad_engine #(
   parameter int LANES       = 4,
   parameter int PIX_W       = 16,
   parameter int ACC_W       = 32,
   parameter int BLOCK_WORDS = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   in_valid,
   input  logic [LANES*PIX_W-1:0] ref_word,
   input  logic [LANES*PIX_W-1:0] cand_word,
   output logic                   done,
   output logic [ACC_W-1:0]       sad_out
);

   localparam int SUM_W  = PIX_W + $clog2(LANES) + 1;
   localparam int NEED_W = PIX_W + $clog2(LANES) + $clog2(BLOCK_WORDS) + 1;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (BLOCK_WORDS < 2) begin : g_bad_words
         $error("BLOCK_WORDS must be at least 2");
      end
      if (ACC_W < NEED_W) begin : g_bad_acc
         $error("ACC_W too narrow for a full-scale block");
      end
   endgenerate

   logic             accept;
   logic             sel_odd;
   logic [SUM_W-1:0] word_sum;

   sad_word_reduce #(
      .LANES (LANES),
      .PIX_W (PIX_W),
      .SUM_W (SUM_W)
   ) u_reduce (
      .ref_word  (ref_word),
      .cand_word (cand_word),
      .word_sum  (word_sum)
   );

   sad_ctrl #(
      .BLOCK_WORDS (BLOCK_WORDS)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .in_valid (in_valid),
      .accept   (accept),
      .sel_odd  (sel_odd),
      .done     (done)
   );

   sad_accum_pair #(
      .ACC_W (ACC_W),
      .SUM_W (SUM_W)
   ) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start),
      .accept   (accept),
      .sel_odd  (sel_odd),
      .word_sum (word_sum),
      .total    (sad_out)
   );

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !start && !accept |=> $stable(sad_out)); // R8

endmodule

// File: tb/sad_engine_tb.sv
`timescale 1ns/1ps
module sad_engine_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic        in_valid;
   logic [63:0] ref_word;
   logic [63:0] cand_word;
   logic        done;
   logic [31:0] sad_out;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sad_engine u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .in_valid  (in_valid),
      .ref_word  (ref_word),
      .cand_word (cand_word),
      .done      (done),
      .sad_out   (sad_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int word_abs(input logic [63:0] r, input logic [63:0] c);
      int s = 0;
      for (int l = 0; l < 4; l++) begin
         int a = int'(r[16*l +: 16]);
         int b = int'(c[16*l +: 16]);
         s += (a > b) ? (a - b) : (b - a);
      end
      return s;
   endfunction

   function automatic logic [63:0] mk_word(input int i, input int k1, input int k2);
      logic [63:0] w;
      for (int l = 0; l < 4; l++) begin
         w[16*l +: 16] = 16'((i * k1 + l * k2 + 7 * i * l) & 16'hFFFF);
      end
      return w;
   endfunction

   task automatic feed(input logic [63:0] r, input logic [63:0] c);
      ref_word  = r;
      cand_word = c;
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid  = 1'b0;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 done after reset", {31'd0, done}, 32'd0);
      chk("R1 sad_out after reset", sad_out, 32'd0);
      feed(64'h0001_0002_0003_0004, 64'h0100_0200_0300_0400);
      chk("R8 word before first start ignored", sad_out, 32'd0);
      chk("R1 done stays low before start", {31'd0, done}, 32'd0);
   endtask

   task automatic t_example();
      logic [63:0] r = {16'd5, 16'd100, 16'd20, 16'd85};
      logic [63:0] c = {16'd33, 16'd0, 16'd211, 16'd45};
      pulse_start();
      chk("R7 total cleared by start", sad_out, 32'd0);
      feed(r, c);
      chk("R2 lanes 40+191+100+28", sad_out, 32'd359);
      for (int i = 1; i < 63; i++) feed(r, c);
      chk("R5 done low after 63 words", {31'd0, done}, 32'd0);
      chk("R4 total after 63 words", sad_out, 32'd22617);
      feed(r, c);
      chk("R5 done high after 64th word", {31'd0, done}, 32'd1);
      chk("R3 block total", sad_out, 32'd22976);
   endtask

   task automatic t_lane_map();
      pulse_start();
      feed({16'd0, 16'd1000, 16'd0, 16'd0}, {16'd7, 16'd10, 16'd0, 16'd0});
      chk("R2 lane 2 and lane 3 placement", sad_out, 32'd997);
      feed(64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001);
      chk("R2 lane 0 placement", sad_out, 32'd997 + 32'd65534);
   endtask

   task automatic t_pattern();
      int exp = 0;
      pulse_start();
      for (int i = 0; i < 64; i++) begin
         logic [63:0] r = mk_word(i, 977, 3001);
         logic [63:0] c = mk_word(i, 1201, 53);
         feed(r, c);
         exp += word_abs(r, c);
         if (i == 20) begin
            ref_word  = 64'hFFFF_FFFF_FFFF_FFFF;
            cand_word = 64'h0;
            repeat (5) @(negedge clk);
            chk("R6 stall keeps total", sad_out, 32'(exp));
            chk("R6 stall keeps done low", {31'd0, done}, 32'd0);
         end
      end
      chk("R4 merged total for varied words", sad_out, 32'(exp));
      chk("R5 done after varied block", {31'd0, done}, 32'd1);
      for (int k = 0; k < 3; k++) feed(64'h1234_5678_9ABC_DEF0, 64'h0);
      chk("R8 words after done ignored", sad_out, 32'(exp));
      repeat (4) @(negedge clk);
      chk("R5 done held", {31'd0, done}, 32'd1);
   endtask

   task automatic t_restart();
      pulse_start();
      for (int i = 0; i < 10; i++) feed(64'h0005_0005_0005_0005, 64'h0);
      chk("R3 partial total", sad_out, 32'd200);
      ref_word  = 64'h00FF_00FF_00FF_00FF;
      cand_word = 64'h0;
      start     = 1'b1;
      in_valid  = 1'b1;
      @(negedge clk);
      start     = 1'b0;
      in_valid  = 1'b0;
      chk("R7 restart clears total", sad_out, 32'd0);
      chk("R8 word with start ignored", {31'd0, done}, 32'd0);
      for (int i = 0; i < 63; i++) feed(64'h0001_0001_0001_0001, 64'h0);
      chk("R7 count restarted", {31'd0, done}, 32'd0);
      feed(64'h0001_0001_0001_0001, 64'h0);
      chk("R7 new block completes", {31'd0, done}, 32'd1);
      chk("R7 new block total", sad_out, 32'd256);
   endtask

   task automatic t_max();
      pulse_start();
      for (int i = 0; i < 32; i++) begin
         feed(64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
         feed(64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
      end
      chk("R9 full-scale total", sad_out, 32'd16776960);
      chk("R9 full-scale done", {31'd0, done}, 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      start     = 1'b0;
      in_valid  = 1'b0;
      ref_word  = '0;
      cand_word = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_example();
      t_lane_map();
      t_pattern();
      t_restart();
      t_max();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule